// File: doc/BRIEF.md
# AXI Link Throughput Monitor

A passive observer sits beside one AXI4 memory-mapped link between an interconnect and a slave. It only listens to the handshake signals of the five channels and never drives any of them. While software has it running, it counts clock cycles, read and write requests, write responses, and the bytes moved in each direction. Software controls it and reads results over a small AXI4-Lite slave port.

Software writes a control word to start, stop or zero the counters, and to choose narrow or wide counters. After a stop, every counter holds its value, so it can be read at leisure. In narrow mode a counter stops at its maximum instead of wrapping. In wide mode each 64-bit counter is read as two 32-bit words. Reading the low word freezes the matching high word in a snapshot, so the two halves always belong together.

Top module: `axi_tput_monitor`

## Requirements
- R1: While stopped (after reset or after a stop), handshakes on the observed link change no counter.
- R2: The cycle counter advances by one on every clock edge from the edge after the start write is accepted up to and including the edge that accepts the stop write.
- R3: The read request and write request counters each add one per AR or AW handshake (valid and ready both high). A valid without ready adds nothing.
- R4: The write response counter adds one per B handshake. A B valid without ready adds nothing.
- R5: Read bytes add DATA_W/8 per R handshake. Write bytes add the number of set WSTRB bits per W handshake.
- R6: Writing the control word with bit2 set zeroes all six counters.
- R7: With control bit3 clear (narrow mode), every counter saturates at 2^NARROW_W-1 (NARROW_W is 32 by default), and high-word reads return 0.
- R8: With bit3 set (wide mode), counters run past the narrow limit. Reading a low word latches that counter's upper 32 bits into a snapshot, and any high-word offset returns the snapshot.
- R9: Register map. The control word is at 0x00 and is written only when byte strobe 0 is set. It holds bit0 start, bit1 stop, bit2 clear and bit3 wide. Reading it returns bit0 = running, bit3 = wide, and 0 in all other bits. Low/high word pairs sit at 0x10/0x14 (cycles), 0x18/0x1C (read bytes), 0x20/0x24 (write bytes), 0x28/0x2C (read requests), 0x30/0x34 (write requests) and 0x38/0x3C (write responses).
- R10: The register port answers every access with OKAY (2'b00) and holds at most one write response and one read response outstanding.
- R11: A control write with both start and stop set leaves the monitor stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_arvalid | input | 1 | Observed read address valid |
| mon_arready | input | 1 | Observed read address ready |
| mon_awvalid | input | 1 | Observed write address valid |
| mon_awready | input | 1 | Observed write address ready |
| mon_wvalid | input | 1 | Observed write data valid |
| mon_wready | input | 1 | Observed write data ready |
| mon_wstrb | input | DATA_W/8 | Observed write byte strobes |
| mon_rvalid | input | 1 | Observed read data valid |
| mon_rready | input | 1 | Observed read data ready |
| mon_bvalid | input | 1 | Observed write response valid |
| mon_bready | input | 1 | Observed write response ready |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_awaddr | input | ADDR_W | Register write address |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data ready |
| s_wdata | input | 32 | Register write data |
| s_wstrb | input | 4 | Register write byte strobes |
| s_bvalid | output | 1 | Register write response valid |
| s_bready | input | 1 | Register write response ready |
| s_bresp | output | 2 | Register write response code |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address ready |
| s_araddr | input | ADDR_W | Register read address |
| s_rvalid | output | 1 | Register read data valid |
| s_rready | input | 1 | Register read data ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Register read response code |

## Verification
The observed link is exercised before a start, inside a start/stop window and after the stop. This shows that only bracketed traffic counts. Inside the window, handshakes are mixed with valids held without ready, and write strobes of full, half and single-byte width are used, so a counter that ignores ready or counts beats instead of strobe bits gives a wrong total. A long run in narrow mode, with the narrow width shortened for the bench, separates saturation from wrapping. The same long run in wide mode shows the limit does not apply there. A combined start-and-stop write and a write with strobe 0 low tell the command priority and the strobe gating apart from plain writes.

// File: rtl/tput_mon_pkg.sv
`timescale 1ns/1ps
package tput_mon_pkg;
  localparam int NUM_CNT = 6;
  localparam int CNT_W   = 64;
  localparam int IDX_W   = $clog2(NUM_CNT);

  typedef enum logic [IDX_W-1:0] {
    IX_CYCLES = 3'd0,
    IX_RBYTES = 3'd1,
    IX_WBYTES = 3'd2,
    IX_RREQS  = 3'd3,
    IX_WREQS  = 3'd4,
    IX_WRESPS = 3'd5
  } cnt_ix_e;

  // control word bit positions
  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_CLEAR = 2;
  localparam int CB_WIDE  = 3;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CNT0 = 8'h10;
endpackage

// File: rtl/tput_mon_counter.sv
`timescale 1ns/1ps
module tput_mon_counter #(
  parameter int CW       = 64,
  parameter int NARROW_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          wide_i,
  input  logic [CW-1:0] inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] NLIM = {{(CW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [CW-1:0] WLIM = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic [CW:0]   sum;

  always_comb begin
    lim = wide_i ? WLIM : NLIM;
    sum = {1'b0, cnt_q} + {1'b0, inc_i};
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      if (cnt_q >= lim)           cnt_d = cnt_q;
      else if (sum > {1'b0, lim}) cnt_d = lim;
      else                        cnt_d = sum[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1: a stopped counter holds its value
  a_r1_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  // R6: clear zeroes the counter on the next edge
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R2: without a clear the counter never goes backwards
  a_r2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q >= $past(cnt_q)));
  // R7: in narrow mode the counter never passes its limit
  a_r7_narrow_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && cnt_q <= NLIM) |=> (cnt_q <= NLIM));
endmodule

// File: rtl/tput_mon_regs.sv
`timescale 1ns/1ps
module tput_mon_regs
  import tput_mon_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            s_awvalid,
  output logic                            s_awready,
  input  logic [ADDR_W-1:0]               s_awaddr,
  input  logic                            s_wvalid,
  output logic                            s_wready,
  input  logic [31:0]                     s_wdata,
  input  logic [3:0]                      s_wstrb,
  output logic                            s_bvalid,
  input  logic                            s_bready,
  output logic [1:0]                      s_bresp,
  input  logic                            s_arvalid,
  output logic                            s_arready,
  input  logic [ADDR_W-1:0]               s_araddr,
  output logic                            s_rvalid,
  input  logic                            s_rready,
  output logic [31:0]                     s_rdata,
  output logic [1:0]                      s_rresp,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_i,
  output logic                            run_o,
  output logic                            clr_o,
  output logic                            wide_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_CNT0);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_CNT0 + 8 * NUM_CNT);

  logic run_q, run_d, wide_q, wide_d;
  logic bvalid_q, bvalid_d, rvalid_q, rvalid_d;
  logic [31:0] rdata_q, rdata_d, snap_q, snap_d;
  logic wr_fire, ctrl_wr, rd_fire, in_cnt, is_hi;
  logic [ADDR_W-1:0] ofs;
  logic [IDX_W-1:0]  idx;
  logic unused_bits;

  assign unused_bits = ^{s_wdata[31:4], s_wstrb[3:1]};

  assign wr_fire = s_awvalid && s_wvalid && !bvalid_q;
  assign ctrl_wr = wr_fire && (s_awaddr == A_CTRL) && s_wstrb[0];
  assign rd_fire = s_arvalid && !rvalid_q;
  assign ofs     = s_araddr - A_LO;
  assign idx     = ofs[IDX_W+2:3];
  assign is_hi   = ofs[2];
  assign in_cnt  = (s_araddr >= A_LO) && (s_araddr < A_HI) && (ofs[1:0] == 2'b00);

  always_comb begin
    run_d    = run_q;
    wide_d   = wide_q;
    bvalid_d = bvalid_q;
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    snap_d   = snap_q;
    if (ctrl_wr) begin
      wide_d = s_wdata[CB_WIDE];
      if (s_wdata[CB_STOP])       run_d = 1'b0;
      else if (s_wdata[CB_START]) run_d = 1'b1;
    end
    if (wr_fire)       bvalid_d = 1'b1;
    else if (s_bready) bvalid_d = 1'b0;
    if (rd_fire) begin
      rvalid_d = 1'b1;
      rdata_d  = 32'h0;
      if (s_araddr == A_CTRL) begin
        rdata_d[CB_START] = run_q;
        rdata_d[CB_WIDE]  = wide_q;
      end else if (in_cnt) begin
        if (is_hi) begin
          rdata_d = snap_q;
        end else begin
          rdata_d = cnt_i[idx][31:0];
          snap_d  = wide_q ? cnt_i[idx][63:32] : 32'h0;
        end
      end
    end else if (s_rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      wide_q   <= 1'b0;
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      snap_q   <= '0;
    end else begin
      run_q    <= run_d;
      wide_q   <= wide_d;
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
      snap_q   <= snap_d;
    end
  end

  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = 2'b00;
  assign s_arready = !rvalid_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = 2'b00;
  assign run_o     = run_q;
  assign wide_o    = wide_q;
  assign clr_o     = ctrl_wr && s_wdata[CB_CLEAR];

  // R10: a pending write response is held until taken
  a_r10_bresp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);
  // R10: no new write is taken while a response is pending
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready);
  // R11: stop dominates start
  a_r11_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && s_wdata[CB_STOP]) |=> !run_o);
  // R9: a lone start runs the monitor
  a_r9_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && s_wdata[CB_START] && !s_wdata[CB_STOP]) |=> run_o);
endmodule

// File: rtl/axi_tput_monitor.sv
`timescale 1ns/1ps
module axi_tput_monitor
  import tput_mon_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mon_arvalid,
  input  logic                  mon_arready,
  input  logic                  mon_awvalid,
  input  logic                  mon_awready,
  input  logic                  mon_wvalid,
  input  logic                  mon_wready,
  input  logic [DATA_W/8-1:0]   mon_wstrb,
  input  logic                  mon_rvalid,
  input  logic                  mon_rready,
  input  logic                  mon_bvalid,
  input  logic                  mon_bready,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  input  logic [31:0]           s_wdata,
  input  logic [3:0]            s_wstrb,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  output logic [1:0]            s_bresp,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  input  logic [ADDR_W-1:0]     s_araddr,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [31:0]           s_rdata,
  output logic [1:0]            s_rresp
);
  localparam int STRB_W = DATA_W / 8;
  localparam logic [CNT_W-1:0] BEAT_BYTES = CNT_W'(STRB_W);

  logic run, clr, wide;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [CNT_W-1:0] inc [NUM_CNT];
  logic [CNT_W-1:0] strb_bytes;

  always_comb begin
    strb_bytes = '0;
    for (int i = 0; i < STRB_W; i++) strb_bytes = strb_bytes + CNT_W'(mon_wstrb[i]);
  end

  always_comb begin
    inc[IX_CYCLES] = CNT_W'(1);
    inc[IX_RBYTES] = (mon_rvalid && mon_rready) ? BEAT_BYTES : '0;
    inc[IX_WBYTES] = (mon_wvalid && mon_wready) ? strb_bytes : '0;
    inc[IX_RREQS]  = CNT_W'(mon_arvalid && mon_arready);
    inc[IX_WREQS]  = CNT_W'(mon_awvalid && mon_awready);
    inc[IX_WRESPS] = CNT_W'(mon_bvalid && mon_bready);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    tput_mon_counter #(.CW(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .en_i  (run),
      .wide_i(wide),
      .inc_i (inc[g]),
      .cnt_o (cnt_all[g])
    );
  end

  tput_mon_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_awvalid(s_awvalid),
    .s_awready(s_awready),
    .s_awaddr (s_awaddr),
    .s_wvalid (s_wvalid),
    .s_wready (s_wready),
    .s_wdata  (s_wdata),
    .s_wstrb  (s_wstrb),
    .s_bvalid (s_bvalid),
    .s_bready (s_bready),
    .s_bresp  (s_bresp),
    .s_arvalid(s_arvalid),
    .s_arready(s_arready),
    .s_araddr (s_araddr),
    .s_rvalid (s_rvalid),
    .s_rready (s_rready),
    .s_rdata  (s_rdata),
    .s_rresp  (s_rresp),
    .cnt_i    (cnt_all),
    .run_o    (run),
    .clr_o    (clr),
    .wide_o   (wide)
  );
endmodule

// File: tb/axi_tput_monitor_test.sv
`timescale 1ns/1ps
module axi_tput_monitor_test;
  localparam int DATA_W = 64;
  localparam int NW     = 10;
  localparam longint NLIM = (64'd1 << NW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic arv, arr, awv, awr, wv, wr, rv, rr, bv, br;
  logic [7:0] ws;
  logic s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rvalid, s_rready;
  logic [7:0] s_awaddr, s_araddr;
  logic [31:0] s_wdata, s_rdata;
  logic [3:0] s_wstrb;
  logic [1:0] s_bresp, s_rresp;

  always #2 clk = ~clk;

  axi_tput_monitor #(.DATA_W(DATA_W), .ADDR_W(8), .NARROW_W(NW)) uut (
    .clk(clk), .rst_n(rst_n),
    .mon_arvalid(arv), .mon_arready(arr), .mon_awvalid(awv), .mon_awready(awr),
    .mon_wvalid(wv), .mon_wready(wr), .mon_wstrb(ws),
    .mon_rvalid(rv), .mon_rready(rr), .mon_bvalid(bv), .mon_bready(br),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  longint e_rb, e_wb, e_rq, e_wq, e_bs;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read response with the queued expectation
  always @(negedge clk) begin
    if (rst_n && s_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected read response", 1, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(s_rdata == e, t, s_rdata, e);
        check(s_rresp == 2'b00, "R10 read OKAY", s_rresp, 0);
      end
    end
    if (rst_n && s_bvalid) check(s_bresp == 2'b00, "R10 write OKAY", s_bresp, 0);
  end

  task automatic lite_wr(input logic [31:0] d, input logic [3:0] st, output time t);
    bit ok;
    @(negedge clk);
    s_awvalid = 1; s_awaddr = 8'h00; s_wvalid = 1; s_wdata = d; s_wstrb = st;
    forever begin
      #1 ok = s_awready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    t = $time;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic lite_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bit ok;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    s_arvalid = 1; s_araddr = a;
    forever begin
      #1 ok = s_arready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    s_arvalid = 0;
    repeat (2) @(negedge clk);
  endtask

  // one cycle of observed-link activity; cnt tells whether the monitor is expected to count
  task automatic link(input logic a_v, a_r, aw_v, aw_r, w_v, w_r, input logic [7:0] st,
                      input logic r_v, r_r, b_v, b_r, input bit cnt);
    @(negedge clk);
    arv = a_v; arr = a_r; awv = aw_v; awr = aw_r; wv = w_v; wr = w_r; ws = st;
    rv = r_v; rr = r_r; bv = b_v; br = b_r;
    if (cnt) begin
      if (a_v && a_r) e_rq++;
      if (aw_v && aw_r) e_wq++;
      if (w_v && w_r) e_wb += $countones(st);
      if (r_v && r_r) e_rb += DATA_W / 8;
      if (b_v && b_r) e_bs++;
    end
  endtask

  task automatic idle();
    link(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic traffic(input bit cnt);
    link(1, 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, cnt);
    link(1, 0, 1, 0, 0, 0, 8'h00, 1, 0, 1, 0, cnt);
    link(0, 0, 1, 1, 1, 1, 8'hFF, 1, 1, 0, 0, cnt);
    link(1, 1, 0, 0, 1, 1, 8'h0F, 1, 1, 1, 1, cnt);
    link(0, 0, 1, 1, 1, 0, 8'hFF, 0, 0, 0, 1, cnt);
    link(0, 0, 0, 0, 1, 1, 8'h01, 1, 1, 1, 1, cnt);
    idle();
  endtask

  task automatic read_all(input string tag, input longint cyc);
    lite_rd(8'h10, cyc[31:0], {tag, " cycles lo"});
    lite_rd(8'h14, cyc[63:32], {tag, " cycles hi"});
    lite_rd(8'h18, e_rb[31:0], {tag, " read bytes"});
    lite_rd(8'h20, e_wb[31:0], {tag, " write bytes"});
    lite_rd(8'h28, e_rq[31:0], {tag, " read requests"});
    lite_rd(8'h30, e_wq[31:0], {tag, " write requests"});
    lite_rd(8'h38, e_bs[31:0], {tag, " write responses"});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    time t1, t2;
    longint cyc;
    s_awvalid = 0; s_awaddr = 0; s_wvalid = 0; s_wdata = 0; s_wstrb = 0; s_bready = 1;
    s_arvalid = 0; s_araddr = 0; s_rready = 1;
    arv = 0; arr = 0; awv = 0; awr = 0; wv = 0; wr = 0; ws = 0; rv = 0; rr = 0; bv = 0; br = 0;
    e_rb = 0; e_wb = 0; e_rq = 0; e_wq = 0; e_bs = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state, R9 control readback
    lite_rd(8'h00, 32'h0, "R9 reset control");
    // R1: traffic before any start is ignored
    traffic(0);
    read_all("R1 before start", 0);

    // R2 R3 R4 R5: counted window in wide mode
    lite_wr(32'h9, 4'hF, t1);
    lite_rd(8'h00, 32'h9, "R9 running wide");
    traffic(1);
    traffic(1);
    repeat (5) idle();
    lite_wr(32'hA, 4'hF, t2);
    cyc = longint'((t2 - t1) / 4);
    // R1: traffic after stop is ignored
    traffic(0);
    lite_rd(8'h00, 32'h8, "R9 stopped wide");
    read_all("R2 R3 R4 R5 window", cyc);

    // R11: start and stop together stay stopped
    lite_wr(32'hB, 4'hF, t1);
    lite_rd(8'h00, 32'h8, "R11 start+stop control");
    repeat (10) idle();
    lite_rd(8'h10, cyc[31:0], "R11 cycles unchanged");

    // R9: write with byte strobe 0 low is ignored
    lite_wr(32'h1, 4'hE, t1);
    lite_rd(8'h00, 32'h8, "R9 strobe-gated control");

    // R6: clear zeroes all counters
    lite_wr(32'hC, 4'hF, t1);
    e_rb = 0; e_wb = 0; e_rq = 0; e_wq = 0; e_bs = 0;
    read_all("R6 after clear", 0);

    // R8: wide mode passes the narrow limit, snapshot high word
    lite_wr(32'h9, 4'hF, t1);
    repeat (1200) idle();
    lite_wr(32'hA, 4'hF, t2);
    cyc = longint'((t2 - t1) / 4);
    check(cyc > NLIM, "R8 window longer than narrow limit", cyc, NLIM + 1);
    lite_rd(8'h10, cyc[31:0], "R8 wide cycles lo");
    lite_rd(8'h14, 32'h0, "R8 wide cycles hi snapshot");
    lite_rd(8'h3C, 32'h0, "R8 other hi offset returns snapshot");

    // R7: narrow mode saturates
    lite_wr(32'h4, 4'hF, t1);
    e_rb = 0;
    lite_wr(32'h1, 4'hF, t1);
    lite_rd(8'h00, 32'h1, "R9 running narrow");
    for (int i = 0; i < 200; i++) link(0, 0, 0, 0, 0, 0, 8'h00, 1, 1, 0, 0, 1);
    repeat (1100) idle();
    lite_wr(32'h2, 4'hF, t2);
    lite_rd(8'h10, NLIM[31:0], "R7 cycles saturate");
    lite_rd(8'h14, 32'h0, "R7 high word zero");
    lite_rd(8'h18, NLIM[31:0], "R7 read bytes saturate");
    lite_rd(8'h28, 32'h0, "R7 no read requests");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule